// File: doc/BRIEF.md
# Bus Ownership and Stall Controller

This block decides which side owns a small processor bus: the on-chip processor or an external master. It watches a single bus-enable input together with the level of the PHI2 clock phase. The block runs on a fast sampling clock. PHI2 arrives as a level input, and a phase boundary is any sampling cycle in which PHI2 differs from its value one cycle earlier.

While bus-enable is high, the processor owns the bus. When bus-enable drops, the PHI2 level in that cycle picks one of two meanings, and that meaning is kept until bus-enable rises again:

- If PHI2 is low, the address lines and write strobe are handed to an external master. That master can then read and write on-chip registers and memory.
- If PHI2 is high, bus direction is left alone and the processor is held as if its ready line were low. This is what allows single-stepping.

An 8-bit configuration register is loaded once, at the first sampling edge after reset is released.

- If bus-enable is low at that edge, the emulation preset is loaded.
- Otherwise the register is cleared.

After that, the register can be rewritten at a fixed internal address, either by the processor or by the external master. Its trace bit causes every on-chip access by the processor to be shown on the external data pins.

Top module: `bus_owner_ctrl`

## Requirements
- R1: At the first clock edge after `rst_n` rises, if `bus_en` is low, `cfg` loads 8'h89 (bits 0, 3 and 7 set). `emul_mode` (bit 0) and `trace_en` (bit 3) then read 1.
- R2: At that same first edge, if `bus_en` is high, `cfg` loads 8'h00. While `rst_n` is low, `cfg` is 8'h00, `addr_oe` is 1, `data_oe` is 0, and the ownership state is processor.
- R3: When `bus_en` is sampled low with `phi2` low while the processor owns the bus, ownership passes to the external master at that edge. From then on, `addr_oe` reads 0 after the next phase boundary.
- R4: While the external master owns the bus:
  - `ext_wr` equals `!ext_we_n`.
  - `ext_rd` is 1 when `ext_we_n` is high and the address is on-chip (`ext_onchip`, or `ext_addr` equal to `CFG_ADDR`).
  - Outside external ownership, both are 0.
- R5: During external ownership, the value loaded into `data_oe` at a phase boundary is 1 only for an on-chip read (see R4). Otherwise it is 0.
- R6: When `bus_en` is sampled low with `phi2` high while the processor owns the bus, ownership goes to the stalled state at that edge. `core_stall` reads 1, and `addr_oe` keeps loading 1 at phase boundaries.
- R7: `core_en` always equals `bus_en & (rdy | ~phi2)`, combinationally.
- R8: In processor ownership, the value loaded into `data_oe` at a phase boundary depends on the access:
  - On-chip access (`cpu_onchip`, or `cpu_addr` equal to `CFG_ADDR`) with `cpu_req`: loads `cfg[3]`.
  - Off-chip access with `cpu_req`: loads `cpu_we`.
  - No `cpu_req`: loads 0.
  - In the stalled state, `data_oe` loads 0.
- R9: The external or stalled state is held until `bus_en` is sampled high, and then ownership returns to the processor. Changes of `phi2` while `bus_en` stays low do not switch between the two states.
- R10: `addr_oe` and `data_oe` change only at the edge that follows a cycle in which `phi2` differs from its previous sampled value. At that edge `addr_oe` loads 1 unless the ownership state is external.
- R11: `cfg` is overwritten with `cpu_wdata[7:0]` in either of two cases:
  - In processor ownership, when `cpu_req`, `cpu_we` and `cpu_addr == CFG_ADDR` are all set.
  - In external ownership, when `ext_we_n` is low and `ext_addr == CFG_ADDR`; the value then comes from `ext_wdata[7:0]`.
  - Stalled or unarmed cycles never write `cfg`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| phi2 | input | 1 | PHI2 phase level |
| bus_en | input | 1 | Bus-enable input |
| rdy | input | 1 | Processor ready input |
| cpu_req | input | 1 | Processor bus access this cycle |
| cpu_we | input | 1 | Processor access is a write |
| cpu_onchip | input | 1 | Processor address decodes to on-chip space |
| cpu_addr | input | ADDR_W | Processor address |
| cpu_wdata | input | DATA_W | Processor write data |
| ext_we_n | input | 1 | External write strobe, active low |
| ext_onchip | input | 1 | External address decodes to on-chip space |
| ext_addr | input | ADDR_W | External master address |
| ext_wdata | input | DATA_W | External master write data |
| addr_oe | output | 1 | Processor drives address lines and write strobe |
| data_oe | output | 1 | Chip drives the external data lines |
| core_stall | output | 1 | Processor held by bus-enable |
| core_en | output | 1 | Effective internal enable |
| ext_wr | output | 1 | External write into on-chip space |
| ext_rd | output | 1 | External read from on-chip space |
| cfg | output | 8 | Configuration register |
| emul_mode | output | 1 | Configuration bit 0 |
| trace_en | output | 1 | Configuration bit 3 |

## Verification
The embedded properties check the following on every cycle:
- The pad enables stay put outside phase boundaries.
- Ownership enters external or stalled according to the PHI2 level at the falling sample, and holds while bus-enable stays low.
- The reset-release preset is loaded correctly.
- The external strobes and the stall are never active together.

Some behaviour only the bench's scenarios show: the contents of the enable registers after a boundary, the trace-driven data enable, and configuration writes from both masters. The bench shows these by comparing every output against a behavioural model over directed sequences and a long random run.

// File: rtl/bus_owner_pkg.sv
package bus_owner_pkg;
    localparam int CFG_W = 8;
    localparam int EMUL_BIT = 0;
    localparam int TRACE_BIT = 3;
    localparam logic [CFG_W-1:0] CFG_EMUL = 8'h89;

    typedef enum logic [1:0] {
        OWN_CPU  = 2'd0,
        OWN_EXT  = 2'd1,
        OWN_HALT = 2'd2
    } own_e;
endpackage

// File: rtl/bus_owner_fsm.sv
module bus_owner_fsm
    import bus_owner_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic phi2,
    input  logic bus_en,
    input  logic armed,
    output own_e mode_q,
    output logic phase_edge
);
    typedef struct packed {
        own_e mode;
        logic phi2;
    } fsm_t;

    fsm_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.phi2 = phi2;
        if (!armed) begin
            st_d.mode = OWN_CPU;
        end else begin
            case (st_q.mode)
                OWN_CPU: if (!bus_en) st_d.mode = phi2 ? OWN_HALT : OWN_EXT;
                default: if (bus_en)  st_d.mode = OWN_CPU;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{mode: OWN_CPU, phi2: 1'b0};
        else        st_q <= st_d;
    end

    assign mode_q     = st_q.mode;
    assign phase_edge = phi2 ^ st_q.phi2;

    // R3
    ext_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == OWN_CPU && armed && !bus_en && !phi2) |=> (mode_q == OWN_EXT));
    // R6
    halt_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == OWN_CPU && armed && !bus_en && phi2) |=> (mode_q == OWN_HALT));
    // R9
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q != OWN_CPU && !bus_en) |=> $stable(mode_q));
endmodule

// File: rtl/bus_owner_cfg.sv
module bus_owner_cfg
    import bus_owner_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_en,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wdata,
    output logic [CFG_W-1:0] cfg_q,
    output logic             armed_q
);
    typedef struct packed {
        logic [CFG_W-1:0] cfg;
        logic             armed;
    } cfg_t;

    cfg_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (!r_q.armed) begin
            r_d.armed = 1'b1;
            r_d.cfg   = bus_en ? '0 : CFG_EMUL;
        end else if (wr_en) begin
            r_d.cfg = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{cfg: '0, armed: 1'b0};
        else        r_q <= r_d;
    end

    assign cfg_q   = r_q.cfg;
    assign armed_q = r_q.armed;

    // R1
    emul_preset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed_q && !bus_en) |=> (cfg_q == CFG_EMUL));
endmodule

// File: rtl/bus_owner_ctrl.sv
module bus_owner_ctrl
    import bus_owner_pkg::*;
#(
    parameter int              ADDR_W   = 16,
    parameter int              DATA_W   = 8,
    parameter logic [ADDR_W-1:0] CFG_ADDR = 16'hFF40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              phi2,
    input  logic              bus_en,
    input  logic              rdy,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic              cpu_onchip,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic              ext_we_n,
    input  logic              ext_onchip,
    input  logic [ADDR_W-1:0] ext_addr,
    input  logic [DATA_W-1:0] ext_wdata,
    output logic              addr_oe,
    output logic              data_oe,
    output logic              core_stall,
    output logic              core_en,
    output logic              ext_wr,
    output logic              ext_rd,
    output logic [7:0]        cfg,
    output logic              emul_mode,
    output logic              trace_en
);
    typedef struct packed {
        logic addr_oe;
        logic data_oe;
    } oe_t;

    own_e             mode;
    logic             phase_edge;
    logic             armed;
    logic [CFG_W-1:0] cfg_q;
    logic             cpu_int, ext_int;
    logic             cfg_wr;
    logic [CFG_W-1:0] cfg_wdata;
    oe_t              oe_d, oe_q;

    assign cpu_int = cpu_onchip || (cpu_addr == CFG_ADDR);
    assign ext_int = ext_onchip || (ext_addr == CFG_ADDR);

    bus_owner_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .phi2       (phi2),
        .bus_en     (bus_en),
        .armed      (armed),
        .mode_q     (mode),
        .phase_edge (phase_edge)
    );

    always_comb begin
        cfg_wr    = 1'b0;
        cfg_wdata = cpu_wdata[CFG_W-1:0];
        if (mode == OWN_CPU && cpu_req && cpu_we && cpu_addr == CFG_ADDR) begin
            cfg_wr = armed;
        end else if (mode == OWN_EXT && !ext_we_n && ext_addr == CFG_ADDR) begin
            cfg_wr    = armed;
            cfg_wdata = ext_wdata[CFG_W-1:0];
        end
    end

    bus_owner_cfg u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .bus_en  (bus_en),
        .wr_en   (cfg_wr),
        .wdata   (cfg_wdata),
        .cfg_q   (cfg_q),
        .armed_q (armed)
    );

    always_comb begin
        oe_d = oe_q;
        if (phase_edge) begin
            oe_d.addr_oe = (mode != OWN_EXT);
            case (mode)
                OWN_CPU: oe_d.data_oe = cpu_req && (cpu_int ? cfg_q[TRACE_BIT] : cpu_we);
                OWN_EXT: oe_d.data_oe = ext_we_n && ext_int;
                default: oe_d.data_oe = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) oe_q <= '{addr_oe: 1'b1, data_oe: 1'b0};
        else        oe_q <= oe_d;
    end

    assign addr_oe    = oe_q.addr_oe;
    assign data_oe    = oe_q.data_oe;
    assign core_stall = (mode == OWN_HALT);
    assign core_en    = bus_en & (rdy | ~phi2);
    assign ext_wr     = (mode == OWN_EXT) && !ext_we_n;
    assign ext_rd     = (mode == OWN_EXT) && ext_we_n && ext_int;
    assign cfg        = cfg_q;
    assign emul_mode  = cfg_q[EMUL_BIT];
    assign trace_en   = cfg_q[TRACE_BIT];

    // R10
    oe_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !phase_edge |=> ($stable(addr_oe) && $stable(data_oe)));
    // R4
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ext_wr, ext_rd, core_stall}));
endmodule

// File: tb/bus_owner_ctrl_tb.sv
module bus_owner_ctrl_tb;
    localparam logic [15:0] CFGA = 16'hFF40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic phi2 = 1'b0, bus_en = 1'b1, rdy = 1'b1;
    logic cpu_req = 1'b0, cpu_we = 1'b0, cpu_onchip = 1'b0;
    logic [15:0] cpu_addr = '0, ext_addr = '0;
    logic [7:0]  cpu_wdata = '0, ext_wdata = '0;
    logic ext_we_n = 1'b1, ext_onchip = 1'b0;
    logic addr_oe, data_oe, core_stall, core_en, ext_wr, ext_rd, emul_mode, trace_en;
    logic [7:0] cfg;

    int vectors = 0, errors = 0, ph_cnt = 0;
    bit finished = 0;

    // behavioural model: 0 processor, 1 external, 2 stalled
    int   m_mode = 0;
    bit   m_armed = 0, m_phq = 0, m_aoe = 1, m_doe = 0;
    logic [7:0] m_cfg = '0;

    always #2.5 clk = ~clk;

    bus_owner_ctrl #(.ADDR_W(16), .DATA_W(8), .CFG_ADDR(CFGA)) u_dut (
        .clk(clk), .rst_n(rst_n), .phi2(phi2), .bus_en(bus_en), .rdy(rdy),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_onchip(cpu_onchip),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .ext_we_n(ext_we_n), .ext_onchip(ext_onchip), .ext_addr(ext_addr),
        .ext_wdata(ext_wdata),
        .addr_oe(addr_oe), .data_oe(data_oe), .core_stall(core_stall),
        .core_en(core_en), .ext_wr(ext_wr), .ext_rd(ext_rd), .cfg(cfg),
        .emul_mode(emul_mode), .trace_en(trace_en)
    );

    task automatic chk(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_armed = 0; m_phq = 0; m_aoe = 1; m_doe = 0; m_cfg = '0;
        end else begin
            bit cint, xint, edge_now;
            int nmode;
            logic [7:0] ncfg;
            cint = cpu_onchip || cpu_addr == CFGA;
            xint = ext_onchip || ext_addr == CFGA;
            edge_now = (phi2 != m_phq);
            ncfg = m_cfg;
            nmode = m_mode;
            if (!m_armed) ncfg = bus_en ? 8'h00 : 8'h89;
            else if (m_mode == 0 && cpu_req && cpu_we && cpu_addr == CFGA) ncfg = cpu_wdata;
            else if (m_mode == 1 && !ext_we_n && ext_addr == CFGA) ncfg = ext_wdata;
            if (m_armed) begin
                if (m_mode == 0 && !bus_en) nmode = phi2 ? 2 : 1;
                else if (m_mode != 0 && bus_en) nmode = 0;
            end
            if (edge_now) begin
                m_aoe = (m_mode != 1);
                if (m_mode == 0) m_doe = cpu_req && (cint ? m_cfg[3] : cpu_we);
                else if (m_mode == 1) m_doe = ext_we_n && xint;
                else m_doe = 0;
            end
            m_phq = phi2; m_cfg = ncfg; m_mode = nmode; m_armed = 1;
        end
    end

    always @(negedge clk) begin
        if (!finished) begin
            chk("R11 cfg", cfg, m_cfg);
            chk("R1 emul_mode", emul_mode, m_cfg[0]);
            chk("R1 trace_en", trace_en, m_cfg[3]);
            chk("R10 addr_oe", addr_oe, m_aoe);
            chk("R5 data_oe", data_oe, m_doe);
            chk("R6 core_stall", core_stall, m_mode == 2);
            chk("R7 core_en", core_en, bus_en & (rdy | ~phi2));
            chk("R4 ext_wr", ext_wr, m_mode == 1 && !ext_we_n);
            chk("R4 ext_rd", ext_rd, m_mode == 1 && ext_we_n &&
                                     (ext_onchip || ext_addr == CFGA));
        end
    end

    task automatic tick();
        @(negedge clk);
        #1;
        ph_cnt++;
        phi2 = ph_cnt[2];
    endtask

    task automatic wait_phase(input bit lvl);
        tick();
        while (phi2 != lvl) tick();
    endtask

    task automatic do_reset(input bit be);
        rst_n = 1'b0; bus_en = be; cpu_req = 0; ext_we_n = 1;
        tick(); tick();
        rst_n = 1'b1;
        tick();
    endtask

    initial begin
        // R1: release with bus enable low
        tick();
        chk("R2 reset addr_oe", addr_oe, 1);
        do_reset(1'b0);
        chk("R1 preset", cfg, 8'h89);
        bus_en = 1; tick();
        // R8: trace on, on-chip processor access drives data at boundary
        cpu_req = 1; cpu_we = 0; cpu_onchip = 1;
        wait_phase(~phi2); tick();
        chk("R8 trace data_oe", data_oe, 1);
        cpu_req = 0; cpu_onchip = 0;

        // R2: release with bus enable high
        do_reset(1'b1);
        chk("R2 cleared", cfg, 8'h00);
        cpu_req = 1; cpu_we = 1; cpu_onchip = 1;
        wait_phase(~phi2); tick();
        chk("R8 no trace data_oe", data_oe, 0);
        // R11: processor write to configuration address
        cpu_addr = CFGA; cpu_wdata = 8'h5A; tick();
        chk("R11 cpu write", cfg, 8'h5A);
        cpu_req = 0; cpu_onchip = 0; cpu_addr = 0;

        // R3: fall during phi2 low
        wait_phase(1'b0);
        bus_en = 0; tick();
        wait_phase(1'b1); tick();
        chk("R3 addr_oe released", addr_oe, 0);
        ext_we_n = 0; ext_addr = CFGA; ext_wdata = 8'hC3; tick();
        chk("R11 ext write", cfg, 8'hC3);
        ext_we_n = 1; ext_addr = 16'h0010; ext_onchip = 1;
        wait_phase(~phi2); tick();
        chk("R5 ext read data_oe", data_oe, 1);
        // R9: phase toggles keep external ownership
        repeat (10) tick();
        chk("R9 held external", addr_oe, 0);
        ext_onchip = 0; bus_en = 1; tick();

        // R6: fall during phi2 high
        wait_phase(1'b1);
        bus_en = 0; tick();
        chk("R6 stalled", core_stall, 1);
        cpu_req = 1; cpu_we = 1; cpu_addr = CFGA; cpu_wdata = 8'h11;
        wait_phase(~phi2); tick();
        chk("R6 addr_oe kept", addr_oe, 1);
        chk("R11 no write when stalled", cfg, 8'hC3);
        repeat (10) tick();
        chk("R9 held stall", core_stall, 1);
        rdy = 0; tick();
        chk("R7 core_en", core_en, 0);
        cpu_req = 0; bus_en = 1; rdy = 1; tick();

        // random traffic covering all requirements
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(0, 15) == 0) bus_en = ~bus_en;
            rdy        = 1'($urandom);
            cpu_req    = 1'($urandom);
            cpu_we     = 1'($urandom);
            cpu_onchip = 1'($urandom);
            cpu_addr   = ($urandom_range(0, 3) == 0) ? CFGA : 16'($urandom);
            cpu_wdata  = 8'($urandom);
            ext_we_n   = 1'($urandom);
            ext_onchip = 1'($urandom);
            ext_addr   = ($urandom_range(0, 3) == 0) ? CFGA : 16'($urandom);
            ext_wdata  = 8'($urandom);
            if (i == 2000) begin
                do_reset(1'($urandom));
            end
            tick();
        end

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            errors++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end
endmodule